// File: doc/BRIEF.md
# Serial Transmitter with Port Fallback and Receive-Error Interlock

This block turns bytes into a serial bit stream on a single transmit pin and decides who owns that pin. While the transmit enable is high, the pin carries frames from the internal engine and its output driver is always on. While the enable is low, the pin becomes a plain port: a direction bit switches its driver on or off and a data bit sets its level. Software can therefore hold the line at mark before transmission starts, or send a break by dropping the enable with the port data at 0.

A one-byte holding register with an empty flag sits in front of a shift engine. In asynchronous mode a frame has a start bit, eight data bits sent LSB first, an optional parity bit and a stop bit, and each bit lasts a fixed number of basic-clock ticks. In synchronous mode only the eight data bits are sent, one per tick, and no frame may start while the receiver reports an overrun, parity or framing error. Dropping the enable resets the engine at once, even in the middle of a frame. Receiver logic and clock generation lie outside the block: the bit-rate tick and the error flags are inputs.

Top module: `sertx_fallback`

## Requirements
- R1: While tx_en_i is 0, tx_oe_o equals port_dir_i and tx_o equals port_dat_i in the same cycle, with no register in the path.
- R2: With tx_en_i at 0, port_dir_i at 1 and port_dat_i at 1, the pin drives mark (tx_o = 1, tx_oe_o = 1).
- R3: While tx_en_i is 1, tx_oe_o is 1, and tx_o is 1 whenever no frame is in progress.
- R4: In asynchronous mode (sync_mode_i = 0) a frame is a 0 start bit, data bits 0 to 7 in that order, a parity bit when par_en_i = 1 (XOR of the data bits, inverted when par_odd_i = 1), then a 1 stop bit; each bit lasts OSR ticks of tick_i.
- R5: In synchronous mode (sync_mode_i = 1) a frame is data bits 0 to 7 in that order with no start, parity or stop bit, each bit lasting one tick_i.
- R6: A pulse on wr_i loads wr_data_i and clears tdr_empty_o on the next edge. A frame starts on the edge after the engine is idle, enabled and the register is full; that edge copies the byte and sets tdr_empty_o, so a write during a frame does not change the frame in flight.
- R7: tx_end_o is 0 while a frame is in progress, becomes 1 at the end of the last bit if tdr_empty_o is 1 then, and stays 0 when another byte is waiting, in which case the next frame starts one idle cycle later.
- R8: Clearing tx_en_i resets the engine on the next edge whatever its state and sets tx_end_o; with port_dir_i = 1 and port_dat_i = 0 the pin goes to 0 in the same cycle (break). A byte still waiting is sent from its first bit after the enable returns.
- R9: In synchronous mode no frame starts while any bit of rx_err_i (bit 0 overrun, bit 1 parity, bit 2 framing) is 1; the waiting byte starts once all are 0. In asynchronous mode rx_err_i has no effect.
- R10: Receive error flags raised during a synchronous frame do not disturb that frame.
- R11: After reset tdr_empty_o = 1, tx_end_o = 1 and the engine is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tx_en_i | input | 1 | Transmit enable; 0 hands the pin to the port bits |
| sync_mode_i | input | 1 | 0 asynchronous, 1 synchronous |
| par_en_i | input | 1 | Parity bit in asynchronous frames |
| par_odd_i | input | 1 | 1 odd parity, 0 even |
| tick_i | input | 1 | Basic-clock enable from the rate generator |
| wr_i | input | 1 | Write strobe for the holding register |
| wr_data_i | input | DATA_W | Byte to transmit |
| port_dir_i | input | 1 | Port direction, 1 output |
| port_dat_i | input | 1 | Port output level |
| rx_err_i | input | 3 | Receive error flags: overrun, parity, framing |
| tdr_empty_o | output | 1 | Holding register empty |
| tx_end_o | output | 1 | Transmission finished and nothing waiting |
| tx_o | output | 1 | Pin output level |
| tx_oe_o | output | 1 | Pin output enable |

## Verification
The assertions watch, on every cycle, that a dropped enable leaves the engine idle with the end flag set, that a synchronous engine never leaves idle while an error flag is up, that a busy engine never shows the end flag, that an asynchronous frame opens with a 0, and how the holding register's empty flag follows writes and frame starts. Bit order, parity polarity, tick counts per bit, the same-cycle break on the pin and the resumption of a waiting byte after an abort can only be shown by the bench's scenarios against its queue-based model.

// File: rtl/sertx_pkg.sv
package sertx_pkg;
  localparam int unsigned RX_ERR_W = 3;
  localparam int unsigned ASYNC_EXTRA = 3;  // start, parity, stop
  typedef enum logic [1:0] {ERR_OVR = 2'd0, ERR_PAR = 2'd1, ERR_FRM = 2'd2} rx_err_idx_e;
endpackage

// File: rtl/sertx_holdreg.sv
module sertx_holdreg #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              take_i,
  output logic [DATA_W-1:0] data_o,
  output logic              empty_o
);
  logic [DATA_W-1:0] data_q;
  logic              empty_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q  <= '0;
      empty_q <= 1'b1;
    end else begin
      if (wr_i) begin
        data_q  <= wr_data_i;
        empty_q <= 1'b0;
      end else if (take_i) begin
        empty_q <= 1'b1;
      end
    end
  end

  assign data_o  = data_q;
  assign empty_o = empty_q;

  a_r6_take_empties: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_i && !wr_i) |=> empty_o);
  a_r6_write_fills: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> !empty_o);
endmodule

// File: rtl/sertx_engine.sv
module sertx_engine
  import sertx_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned OSR    = 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                en_i,
  input  logic                sync_i,
  input  logic                par_en_i,
  input  logic                par_odd_i,
  input  logic                tick_i,
  input  logic [RX_ERR_W-1:0] rx_err_i,
  input  logic                pend_i,
  input  logic [DATA_W-1:0]   data_i,
  output logic                start_o,
  output logic                bit_o,
  output logic                tend_o
);
  localparam int unsigned FRAME_W = DATA_W + ASYNC_EXTRA;
  localparam int unsigned LEFT_W  = $clog2(FRAME_W + 1);
  localparam int unsigned CNT_W   = (OSR > 1) ? $clog2(OSR) : 1;

  logic               busy_q, tend_q;
  logic [FRAME_W-1:0] frame_q, frame_d;
  logic [LEFT_W-1:0]  left_q, nbits_d;
  logic [CNT_W-1:0]   cnt_q;
  logic               start, bit_done, err_block;

  assign err_block = sync_i && (|rx_err_i);
  assign start     = en_i && !busy_q && pend_i && !err_block;
  assign bit_done  = busy_q && tick_i && (sync_i || (cnt_q == CNT_W'(OSR - 1)));

  always_comb begin
    frame_d = '1;
    if (sync_i) begin
      frame_d[DATA_W-1:0] = data_i;
      nbits_d = LEFT_W'(DATA_W);
    end else begin
      frame_d[0]          = 1'b0;
      frame_d[DATA_W:1]   = data_i;
      frame_d[DATA_W+1]   = par_en_i ? ((^data_i) ^ par_odd_i) : 1'b1;
      nbits_d = par_en_i ? LEFT_W'(DATA_W + 3) : LEFT_W'(DATA_W + 2);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      tend_q  <= 1'b1;
      frame_q <= '1;
      left_q  <= '0;
      cnt_q   <= '0;
    end else if (!en_i) begin
      busy_q <= 1'b0;
      tend_q <= 1'b1;
      left_q <= '0;
      cnt_q  <= '0;
    end else if (start) begin
      busy_q  <= 1'b1;
      tend_q  <= 1'b0;
      frame_q <= frame_d;
      left_q  <= nbits_d;
      cnt_q   <= '0;
    end else if (bit_done) begin
      frame_q <= {1'b1, frame_q[FRAME_W-1:1]};
      left_q  <= left_q - 1'b1;
      cnt_q   <= '0;
      if (left_q == LEFT_W'(1)) begin
        busy_q <= 1'b0;
        if (!pend_i) tend_q <= 1'b1;
      end
    end else if (busy_q && tick_i) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign start_o = start;
  assign bit_o   = busy_q ? frame_q[0] : 1'b1;
  assign tend_o  = tend_q;

  a_r8_abort_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (!busy_q && tend_o));
  a_r9_err_blocks_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sync_i && (|rx_err_i) && !busy_q) |=> !busy_q);
  a_r7_no_end_when_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> !tend_o);
  a_r4_start_bit_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(busy_q) && !$past(sync_i)) |-> (bit_o == 1'b0));
endmodule

// File: rtl/sertx_pinmux.sv
module sertx_pinmux (
  input  logic en_i,
  input  logic eng_bit_i,
  input  logic port_dir_i,
  input  logic port_dat_i,
  output logic pin_o,
  output logic pin_oe_o
);
  always_comb begin
    if (en_i) begin
      pin_o    = eng_bit_i;
      pin_oe_o = 1'b1;
    end else begin
      pin_o    = port_dat_i;
      pin_oe_o = port_dir_i;
    end
  end
endmodule

// File: rtl/sertx_fallback.sv
module sertx_fallback
  import sertx_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned OSR    = 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                tx_en_i,
  input  logic                sync_mode_i,
  input  logic                par_en_i,
  input  logic                par_odd_i,
  input  logic                tick_i,
  input  logic                wr_i,
  input  logic [DATA_W-1:0]   wr_data_i,
  input  logic                port_dir_i,
  input  logic                port_dat_i,
  input  logic [RX_ERR_W-1:0] rx_err_i,
  output logic                tdr_empty_o,
  output logic                tx_end_o,
  output logic                tx_o,
  output logic                tx_oe_o
);
  logic [DATA_W-1:0] hold_data;
  logic              take, eng_bit;

  sertx_holdreg #(.DATA_W(DATA_W)) u_hold (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_i     (wr_i),
    .wr_data_i(wr_data_i),
    .take_i   (take),
    .data_o   (hold_data),
    .empty_o  (tdr_empty_o)
  );

  sertx_engine #(.DATA_W(DATA_W), .OSR(OSR)) u_eng (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (tx_en_i),
    .sync_i   (sync_mode_i),
    .par_en_i (par_en_i),
    .par_odd_i(par_odd_i),
    .tick_i   (tick_i),
    .rx_err_i (rx_err_i),
    .pend_i   (!tdr_empty_o),
    .data_i   (hold_data),
    .start_o  (take),
    .bit_o    (eng_bit),
    .tend_o   (tx_end_o)
  );

  sertx_pinmux u_pin (
    .en_i      (tx_en_i),
    .eng_bit_i (eng_bit),
    .port_dir_i(port_dir_i),
    .port_dat_i(port_dat_i),
    .pin_o     (tx_o),
    .pin_oe_o  (tx_oe_o)
  );

  a_r3_idle_mark: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_en_i && tx_end_o) |-> (tx_o && tx_oe_o));
endmodule

// File: tb/sertx_fallback_tb.sv
module sertx_fallback_tb_top;
  localparam int OSR = 16;
  logic clk = 1'b0, rst_n = 1'b0;
  logic en = 0, sync_m = 0, par_en = 0, par_odd = 0, tick = 0, wr = 0;
  logic [7:0] wdata = '0;
  logic dir = 1, dat = 1;
  logic [2:0] err = '0;
  logic empty_o, tend_o, tx_o, oe_o;

  int vecs = 0, fails = 0;
  string cur_req = "R11";
  bit done = 0;

  // reference model state
  int q[$];
  int m_cnt = 0;
  bit m_empty = 1, m_tend = 1;
  logic [7:0] m_tdr = '0;

  always #2 clk = ~clk;

  sertx_fallback #(.DATA_W(8), .OSR(OSR)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .tx_en_i(en), .sync_mode_i(sync_m),
    .par_en_i(par_en), .par_odd_i(par_odd), .tick_i(tick), .wr_i(wr),
    .wr_data_i(wdata), .port_dir_i(dir), .port_dat_i(dat), .rx_err_i(err),
    .tdr_empty_o(empty_o), .tx_end_o(tend_o), .tx_o(tx_o), .tx_oe_o(oe_o));

  always @(posedge clk) begin
    bit old_empty, st;
    old_empty = m_empty;
    st = 0;
    if (!rst_n) begin
      q.delete(); m_cnt = 0; m_empty = 1; m_tend = 1; m_tdr = '0;
    end else begin
      if (!en) begin
        q.delete(); m_cnt = 0; m_tend = 1;
      end else if (q.size() > 0) begin
        if (tick) begin
          if (sync_m || m_cnt == OSR - 1) begin
            void'(q.pop_front()); m_cnt = 0;
            if (q.size() == 0 && old_empty) m_tend = 1;
          end else m_cnt++;
        end
      end else if (!old_empty && (!sync_m || err == 3'b000)) begin
        st = 1; m_tend = 0; m_cnt = 0;
        if (!sync_m) q.push_back(0);
        for (int i = 0; i < 8; i++) q.push_back(int'(m_tdr[i]));
        if (!sync_m) begin
          if (par_en) q.push_back(int'((^m_tdr) ^ par_odd));
          q.push_back(1);
        end
      end
      if (wr) begin m_tdr = wdata; m_empty = 0; end
      else if (st) m_empty = 1;
    end
  end

  always @(negedge clk) begin
    logic e_tx, e_oe;
    if (!done) begin
      e_oe = en ? 1'b1 : dir;
      e_tx = en ? ((q.size() > 0) ? q[0][0] : 1'b1) : dat;
      vecs++;
      if (tx_o !== e_tx || oe_o !== e_oe || empty_o !== m_empty || tend_o !== m_tend) begin
        fails++;
        $display("FAIL %s t=%0t: tx/oe/empty/end=%b%b%b%b expected %b%b%b%b", cur_req, $time,
                 tx_o, oe_o, empty_o, tend_o, e_tx, e_oe, m_empty, m_tend);
      end
    end
  end

  initial forever begin
    @(posedge clk); #1 tick = ~tick;
  end

  task automatic cyc(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic put(logic [7:0] b);
    wr = 1; wdata = b; cyc(1); wr = 0;
  endtask

  task automatic drain();
    for (int i = 0; i < 2000; i++) begin
      if (q.size() == 0 && m_empty) break;
      cyc(1);
    end
    cyc(3);
  endtask

  initial begin
    cyc(3);
    // R11 reset state, explicit check
    vecs++;
    if (empty_o !== 1'b1 || tend_o !== 1'b1) begin
      fails++; $display("FAIL R11: empty/end=%b%b expected 11", empty_o, tend_o);
    end
    rst_n = 1; cyc(2);
    cur_req = "R2"; dir = 1; dat = 1; cyc(4);
    cur_req = "R1"; dir = 0; cyc(2); dat = 0; cyc(1); dat = 1; cyc(1); dir = 1; dat = 0; cyc(2);
    // byte written while disabled waits
    put(8'h3C); cyc(5);
    cur_req = "R3"; dat = 1; en = 1; cyc(1);
    cur_req = "R4"; drain();
    cur_req = "R4"; par_en = 1; par_odd = 0; put(8'hA5); drain();
    par_odd = 1; put(8'h81); drain();
    cur_req = "R6"; par_en = 0; put(8'h5A); cyc(30); put(8'hF0); cyc(10);
    cur_req = "R7"; drain();
    cur_req = "R9"; err = 3'b100; put(8'h11); drain();  // async ignores errors
    err = 3'b000;
    cur_req = "R5"; sync_m = 1; put(8'hC3); drain(); put(8'h6E); put(8'h01); drain();
    cur_req = "R9"; err = 3'b001; put(8'h96); cyc(40); err = 3'b010; cyc(20);
    err = 3'b000; drain();
    cur_req = "R10"; put(8'h7B); cyc(4); err = 3'b110; cyc(30); err = 3'b000; drain();
    cur_req = "R8"; sync_m = 0; put(8'hE7); cyc(70); dir = 1; dat = 0; en = 0; cyc(1);
    put(8'h2D); cyc(20); dat = 1; cyc(2); en = 1; drain();
    put(8'h42); cyc(100); en = 0; cyc(3); en = 1; cyc(2);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  end

  initial begin
    #400000;
    fails++;
    $display("FAIL watchdog: run hung, expected completion");
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  end
endmodule